// File: doc/BRIEF.md
# PHY Test-Port Register Target

This block is the far end of a narrow, two-word test port that configures a PHY. Software cannot address the PHY's byte-wide configuration registers directly. It first posts a register index and then a value, and it commits each of these phases by pulsing a strobe bit. The block tracks which phase is in progress and holds the most recently posted index. It writes the payload byte into an internal bank. The whole bank drives parallel outputs: clock-lane timing bytes, per-data-lane timing bytes, PLL bytes, and the PLL fields decoded from them.

The strobe word is treated as asynchronous. Both of its bits pass through a synchroniser, and only the rising edge of the synchronised bit acts. A pulse of any length therefore performs exactly one action. The control word must be stable before the strobe rises. It is sampled in the cycle the synchronised edge is seen. The port has no back-pressure. Both words are level-held by the host, so there is no valid/ready pair, and the host paces itself by holding each strobe level for at least three clock cycles.

Top module: `phy_tport_target`

## Requirements
- R1: After reset every bank register reads 0x00, so every configuration output and every decoded PLL field is zero.
- R2: A commit pulse (tp_strobe bit 1) with the select flag (tp_ctl bit 16) set stores tp_ctl[7:0] as the target index and leaves every bank register unchanged.
- R3: A commit pulse with the select flag clear writes tp_ctl[7:0] into the register at the stored index; no other register changes.
- R4: The action is taken only on the rising edge of the synchronised strobe bit; holding the strobe high, or changing tp_ctl while it is high, causes no further change.
- R5: A value phase that is not preceded by a new index phase writes to the index stored most recently.
- R6: Index map: clock lane at 0x00..0x04 (LPX, HS-prepare, HS-zero, HS-trail, wakeup; byte k at clk_lane_cfg[8k+:8]); data lane n at 0x08+8n+k for k = 0..6 (LPX, HS-prepare, HS-zero, HS-trail, TA-go, TA-get, wakeup; byte at data_lane_cfg[(7n+k)*8+:8]); PLL bytes at 0x30..0x35 (byte j at pll_cfg[8j+:8]).
- R7: A value phase whose stored index is not in the R6 map (for example 0x05..0x07, 0x0F, 0x36 and above) changes no register.
- R8: A rising edge of the clear bit (tp_strobe bit 0) sets every bank register to 0x00 and keeps the stored index.
- R9: When the clear and commit edges are seen in the same cycle, the clear is applied and the write is discarded.
- R10: From PLL byte 0x31, bit 5 drives pll_div5_en, bit 4 pll_div1_en, bits 3:1 pll_fb_sel and bit 0 pll_bw_en; from PLL byte 0x34, bit 7 drives pll_prediv_bypass and bits 6:0 pll_prescale.
- R11: A register written by a strobe that rises before clock edge 1 keeps its old value after edge 2 and holds the new value after edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tp_ctl | input | 17 | Bit 16 is the index-select flag, bits 7:0 are the payload, and bits 15:8 are unused |
| tp_strobe | input | 2 | Bit 1 is the commit strobe, bit 0 is the bank clear |
| clk_lane_cfg | output | 40 | Clock-lane timing bytes |
| data_lane_cfg | output | 224 | Data-lane timing bytes, 7 per lane, 4 lanes |
| pll_cfg | output | 48 | Six PLL configuration bytes |
| pll_div5_en | output | 1 | Divide-by-5 select |
| pll_div1_en | output | 1 | Divide-by-1 select |
| pll_fb_sel | output | 3 | Feedback divider field |
| pll_bw_en | output | 1 | Bandwidth enable |
| pll_prediv_bypass | output | 1 | Pre-divider bypass |
| pll_prescale | output | 7 | Prescaler value |

## Verification
The main sweep covers all 256 index values. Each index phase is followed by a value phase carrying a byte derived from the index. A check after each index phase shows that an index alone changes nothing. A check after each value phase shows which slot the index selected, or that nothing moved for an unmapped index. Separate patterns cover these cases:
- a value phase with no new index;
- a strobe held high while the payload changes;
- clear and commit rising together;
- a clear followed by a value phase, which shows the index is retained;
- a latency probe sampled after edges 2 and 3.

Decoded PLL fields are checked with bytes whose bits differ in every field.

// File: rtl/phy_tport_pkg.sv
package phy_tport_pkg;

  localparam int CLK_REGS    = 5;
  localparam int LANE_REGS   = 7;
  localparam int LANE_STRIDE = 8;
  localparam int PLL_REGS    = 6;
  localparam int LANE_BASE   = 8;
  localparam int PLL_BASE    = 48;

  typedef struct packed {
    logic       hit;
    logic [7:0] idx;
  } tp_slot_t;

  // Map a test-port index onto a flat bank slot.
  function automatic tp_slot_t tp_decode(input logic [7:0] a, input int lanes);
    tp_slot_t s;
    int ai;
    int off;
    ai    = int'(a);
    s.hit = 1'b0;
    s.idx = '0;
    if (ai < CLK_REGS) begin
      s.hit = 1'b1;
      s.idx = a;
    end else if (ai >= LANE_BASE && ai < LANE_BASE + LANE_STRIDE * lanes) begin
      off = ai - LANE_BASE;
      if ((off % LANE_STRIDE) < LANE_REGS) begin
        s.hit = 1'b1;
        s.idx = 8'(CLK_REGS + (off / LANE_STRIDE) * LANE_REGS + (off % LANE_STRIDE));
      end
    end else if (ai >= PLL_BASE && ai < PLL_BASE + PLL_REGS) begin
      s.hit = 1'b1;
      s.idx = 8'(CLK_REGS + LANE_REGS * lanes + (ai - PLL_BASE));
    end
    return s;
  endfunction

endpackage

// File: rtl/phy_tport_sync.sv
module phy_tport_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] rise
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign rise = stg_q[STAGES-1] & ~prev_q;

  // R4: an edge pulse never lasts two cycles on the same bit
  p_single_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/phy_tport_phase.sv
module phy_tport_phase
  import phy_tport_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_rise,
  input  logic       clr_rise,
  input  logic       sel_flag,
  input  logic [7:0] payload,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data
);

  logic [7:0] addr_q;
  tp_slot_t   slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   addr_q <= '0;
    else if (cmd_rise && sel_flag) addr_q <= payload;
  end

  always_comb begin
    slot    = tp_decode(addr_q, LANES);
    wr_en   = cmd_rise && !sel_flag && !clr_rise && slot.hit;
    wr_idx  = slot.idx;
    wr_data = payload;
  end

  // R2, R5, R8: the stored index only moves on an index phase
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_rise && sel_flag) |=> $stable(addr_q));

endmodule

// File: rtl/phy_tport_bank.sv
module phy_tport_bank #(
  parameter int NREG = 39
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_en,
  input  logic [7:0]      wr_idx,
  input  logic [7:0]      wr_data,
  output logic [NREG*8-1:0] bank_q
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           bank_q[g*8 +: 8] <= '0;
      else if (clr)                         bank_q[g*8 +: 8] <= '0;
      else if (wr_en && wr_idx == 8'(g))    bank_q[g*8 +: 8] <= wr_data;
    end
  end

  // R3, R7: without a write or clear nothing changes
  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr) |=> $stable(bank_q));

  // R8, R9: a clear empties the bank the next cycle
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bank_q == '0));

endmodule

// File: rtl/phy_tport_target.sv
module phy_tport_target
  import phy_tport_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NREG       = CLK_REGS + LANE_REGS * LANES + PLL_REGS,
  localparam int DL_W       = LANE_REGS * LANES * 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [16:0]     tp_ctl,
  input  logic [1:0]      tp_strobe,
  output logic [CLK_REGS*8-1:0] clk_lane_cfg,
  output logic [DL_W-1:0] data_lane_cfg,
  output logic [PLL_REGS*8-1:0] pll_cfg,
  output logic            pll_div5_en,
  output logic            pll_div1_en,
  output logic [2:0]      pll_fb_sel,
  output logic            pll_bw_en,
  output logic            pll_prediv_bypass,
  output logic [6:0]      pll_prescale
);

  logic [1:0]        rise;
  logic              wr_en;
  logic [7:0]        wr_idx;
  logic [7:0]        wr_data;
  logic [NREG*8-1:0] bank_q;
  logic              unused_mid;

  assign unused_mid = ^tp_ctl[15:8];

  phy_tport_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (tp_strobe),
    .rise     (rise)
  );

  phy_tport_phase #(.LANES(LANES)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_rise (rise[1]),
    .clr_rise (rise[0]),
    .sel_flag (tp_ctl[16]),
    .payload  (tp_ctl[7:0]),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  phy_tport_bank #(.NREG(NREG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (rise[0]),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .bank_q  (bank_q)
  );

  assign clk_lane_cfg  = bank_q[0 +: CLK_REGS*8];
  assign data_lane_cfg = bank_q[CLK_REGS*8 +: DL_W];
  assign pll_cfg       = bank_q[CLK_REGS*8 + DL_W +: PLL_REGS*8];

  // PLL byte 1: divider flags, feedback field, bandwidth enable
  assign pll_div5_en       = pll_cfg[8+5];
  assign pll_div1_en       = pll_cfg[8+4];
  assign pll_fb_sel        = pll_cfg[8+1 +: 3];
  assign pll_bw_en         = pll_cfg[8+0];
  // PLL byte 4: pre-divider bypass above prescaler
  assign pll_prediv_bypass = pll_cfg[32+7];
  assign pll_prescale      = pll_cfg[32 +: 7];

  // R2: an index phase never touches the bank
  p_index_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[1] && tp_ctl[16] && !rise[0]) |=> $stable(bank_q));

endmodule

// File: tb/phy_tport_target_bench.sv
module phy_tport_target_bench;

  localparam int L    = 4;
  localparam int NREG = 5 + 7 * L + 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] tp_ctl = '0;
  logic [1:0]  tp_strobe = '0;
  logic [39:0] clk_lane_cfg;
  logic [7*L*8-1:0] data_lane_cfg;
  logic [47:0] pll_cfg;
  logic        pll_div5_en, pll_div1_en, pll_bw_en, pll_prediv_bypass;
  logic [2:0]  pll_fb_sel;
  logic [6:0]  pll_prescale;

  int  n_run = 0;
  int  n_fail = 0;
  int  cyc = 0;
  bit  done = 0;
  logic [7:0] exp_bank [NREG];

  always #4 clk = ~clk;

  phy_tport_target u_phy_tport_target (
    .clk(clk), .rst_n(rst_n), .tp_ctl(tp_ctl), .tp_strobe(tp_strobe),
    .clk_lane_cfg(clk_lane_cfg), .data_lane_cfg(data_lane_cfg), .pll_cfg(pll_cfg),
    .pll_div5_en(pll_div5_en), .pll_div1_en(pll_div1_en), .pll_fb_sel(pll_fb_sel),
    .pll_bw_en(pll_bw_en), .pll_prediv_bypass(pll_prediv_bypass),
    .pll_prescale(pll_prescale)
  );

  // Index to slot per R6; -1 for unmapped (R7)
  function automatic int slot_of(input int a);
    if (a < 5) return a;
    if (a >= 8 && a < 8 + 8 * L && ((a - 8) % 8) < 7)
      return 5 + ((a - 8) / 8) * 7 + (a - 8) % 8;
    if (a >= 48 && a < 54) return 5 + 7 * L + (a - 48);
    return -1;
  endfunction

  task automatic check_bank(input string tag);
    logic [NREG*8-1:0] e;
    logic [NREG*8-1:0] got;
    for (int i = 0; i < NREG; i++) e[i*8 +: 8] = exp_bank[i];
    got = {pll_cfg, data_lane_cfg, clk_lane_cfg};
    n_run++;
    if (got !== e) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, e);
    end
  endtask

  task automatic check_val(input string tag, input logic [7:0] act, input logic [7:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic phase(input bit flag, input logic [7:0] b);
    tp_ctl = {flag, 8'h00, b};
    wait_n(1);
    tp_strobe[1] = 1'b1;
    wait_n(5);
    tp_strobe[1] = 1'b0;
    wait_n(5);
  endtask

  task automatic clear_bank();
    tp_strobe[0] = 1'b1;
    wait_n(5);
    tp_strobe[0] = 1'b0;
    wait_n(5);
    for (int i = 0; i < NREG; i++) exp_bank[i] = 8'h00;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int s;
    for (int i = 0; i < NREG; i++) exp_bank[i] = 8'h00;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    check_bank("R1 reset bank");
    check_val("R1 reset fields", {pll_div5_en, pll_div1_en, pll_fb_sel, pll_bw_en, pll_prediv_bypass}, 8'h00);

    // Sweep every index: index phase then value phase (R2, R3, R6, R7)
    for (int a = 0; a < 256; a++) begin
      phase(1'b1, 8'(a));
      check_bank("R2 index phase leaves bank");
      phase(1'b0, 8'(a) ^ 8'hA5);
      s = slot_of(a);
      if (s >= 0) exp_bank[s] = 8'(a) ^ 8'hA5;
      check_bank(s >= 0 ? "R3 R6 mapped write" : "R7 unmapped ignored");
    end

    // R8 clear
    clear_bank();
    check_bank("R8 clear");

    // R10 decoded fields
    phase(1'b1, 8'h31); phase(1'b0, 8'h2B); exp_bank[slot_of(8'h31)] = 8'h2B;
    check_val("R10 div5", {7'd0, pll_div5_en}, 8'h01);
    check_val("R10 div1", {7'd0, pll_div1_en}, 8'h00);
    check_val("R10 fb_sel", {5'd0, pll_fb_sel}, 8'h05);
    check_val("R10 bw_en", {7'd0, pll_bw_en}, 8'h01);
    phase(1'b1, 8'h34); phase(1'b0, 8'h93); exp_bank[slot_of(8'h34)] = 8'h93;
    check_val("R10 bypass", {7'd0, pll_prediv_bypass}, 8'h01);
    check_val("R10 prescale", {1'b0, pll_prescale}, 8'h13);
    check_bank("R10 bank");

    // R5 value phase without new index
    phase(1'b0, 8'h11); exp_bank[slot_of(8'h34)] = 8'h11;
    check_bank("R5 reuse index");

    // R8 index retained across clear
    clear_bank();
    phase(1'b0, 8'h22); exp_bank[slot_of(8'h34)] = 8'h22;
    check_bank("R8 index kept after clear");

    // R9 clear and commit together
    tp_ctl = {1'b0, 8'h00, 8'h33};
    wait_n(1);
    tp_strobe = 2'b11;
    wait_n(5);
    tp_strobe = 2'b00;
    wait_n(5);
    for (int i = 0; i < NREG; i++) exp_bank[i] = 8'h00;
    check_bank("R9 clear wins");

    // R4 one action per pulse
    phase(1'b1, 8'h02);
    tp_ctl = {1'b0, 8'h00, 8'h44};
    wait_n(1);
    tp_strobe[1] = 1'b1;
    wait_n(5);
    tp_ctl = {1'b0, 8'h00, 8'h55};
    wait_n(5);
    tp_ctl = {1'b1, 8'h00, 8'h0A};
    wait_n(5);
    tp_strobe[1] = 1'b0;
    wait_n(5);
    exp_bank[2] = 8'h44;
    check_bank("R4 single action per pulse");

    // R11 latency
    phase(1'b1, 8'h03);
    tp_ctl = {1'b0, 8'h00, 8'h66};
    wait_n(1);
    tp_strobe[1] = 1'b1;
    wait_n(2);
    check_val("R11 old after edge 2", clk_lane_cfg[24 +: 8], 8'h00);
    wait_n(1);
    check_val("R11 new after edge 3", clk_lane_cfg[24 +: 8], 8'h66);
    tp_strobe[1] = 1'b0;
    wait_n(5);
    exp_bank[3] = 8'h66;
    check_bank("R11 bank");

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule